// File: doc/BRIEF.md
# Privileged Interrupt Priority Selector

This block decides which interrupt a hart takes and reports its cause number. It receives the pending and enable vectors of the low interrupt causes, a delegation mask, the current privilege level, the machine and supervisor global enable bits, a debug request and a bus-error signal. From these it forms three groups: debug, machine and supervisor. It gates each group by privilege and picks one winner by a fixed order that is not numeric.

The bus-error cause sits at number 128, outside the enable and delegation vectors. It cannot be masked and it cannot be delegated. Whenever the machine group is allowed, it outranks every other machine cause. The result is registered once per clock. The cause output is wide enough to hold 128. A small combinational helper also filters a value written to the cause register, keeping only the bits that such a register implements.

Top module: `irq_prio_sel`

## Requirements
- R1: `irq_take_o` and `irq_cause_o` are registered. They reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low both are 0.
- R2: A debug request wins over everything, with cause 14. Privilege and enables do not affect it. After debug, the whole machine group outranks the whole supervisor group.
- R3: Privilege is encoded U=2'd0, S=2'd1, M=2'd3. The machine group is pending & ~delegation. It is allowed when the privilege is not M, or when `m_gie_i` is 1.
- R4: The supervisor group is pending & delegation. It is allowed when the privilege is U, or when the privilege is S and `s_gie_i` is 1.
- R5: A low cause n is pending only when bit n of both `pend_i` and `en_i` is set. When `buserr_i` is 1, cause 128 is pending whatever `en_i` holds.
- R6: Cause 128 is never delegated. Delegation bits 3, 7 and 11 are forced to 0, so those causes always belong to the machine group.
- R7: Within a group, causes 12 and above are scanned first, from the highest index downwards (128, then 15 down to 12). After them come 11, 3, 7, 9, 1, 5, 8, 0, 4, in that order. The winner is the first set bit of the scan.
- R8: When no gated bit is set in any group, `irq_take_o` is 0 and `irq_cause_o` is 0.
- R9: `cause_wr_o` equals `cause_wdata_i` with every bit cleared except bit 63 and bits 7:0. The cause width of 8 is the width needed to hold 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_i | input | 16 | Pending bits of the low causes |
| en_i | input | 16 | Enable bits of the low causes |
| deleg_i | input | 16 | Delegation mask (1 = to supervisor) |
| priv_i | input | 2 | Current privilege (U=0, S=1, M=3) |
| m_gie_i | input | 1 | Machine global interrupt enable |
| s_gie_i | input | 1 | Supervisor global interrupt enable |
| dbg_req_i | input | 1 | Debug interrupt request |
| buserr_i | input | 1 | Bus-error interrupt request |
| cause_wdata_i | input | 64 | Value written to the cause register |
| irq_take_o | output | 1 | An interrupt is taken (registered) |
| irq_cause_o | output | 8 | Winning cause number (registered) |
| cause_wr_o | output | 64 | Write data after the cause-register mask |

## Verification
The taken flag and the cause are due at the first rising edge after the inputs are applied. The bench changes inputs just after a falling edge. It computes the expected pair from its own priority model at that moment. It compares the outputs at the next falling edge, which is one register stage later. The masked write value is combinational, so it is compared a short delay after its input changes, before any edge. One directed step also confirms that the registered output still holds the old result just before the edge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  localparam int NONSTD_BASE = 12;
  localparam int STD_CNT     = 9;
  localparam int NGRP        = 3;

  // Scan slot k of the standard causes (machine ext/sw/timer first).
  function automatic int std_slot(input int k);
    case (k)
      0:       return 11;
      1:       return 3;
      2:       return 7;
      3:       return 9;
      4:       return 1;
      5:       return 5;
      6:       return 8;
      7:       return 0;
      default: return 4;
    endcase
  endfunction

  function automatic logic mach_allowed(input priv_e p, input logic mgie);
    return (p != PRIV_M) || mgie;
  endfunction

  function automatic logic sup_allowed(input priv_e p, input logic sgie);
    return (p == PRIV_U) || ((p == PRIV_S) && sgie);
  endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
  import irq_prio_pkg::*;
#(
  parameter int LOW_W        = 16,
  parameter bit HAS_BUSERR   = 1'b1,
  parameter int BUSERR_CAUSE = 128,
  localparam int PEND_W      = HAS_BUSERR ? BUSERR_CAUSE + 1 : LOW_W
) (
  input  logic [LOW_W-1:0]  pend_i,
  input  logic [LOW_W-1:0]  en_i,
  input  logic [LOW_W-1:0]  deleg_i,
  input  logic [1:0]        priv_i,
  input  logic              m_gie_i,
  input  logic              s_gie_i,
  input  logic              buserr_i,
  output logic [PEND_W-1:0] mach_vec_o,
  output logic [PEND_W-1:0] sup_vec_o,
  output logic              mach_ok_o,
  output logic              sup_ok_o
);

  localparam logic [LOW_W-1:0] FIXED_M =
    LOW_W'((1 << 3) | (1 << 7) | (1 << 11));

  logic [PEND_W-1:0] pending;
  logic [PEND_W-1:0] deleg_eff;
  logic [PEND_W-1:0] low_pend;

  assign low_pend  = PEND_W'(pend_i & en_i);
  assign deleg_eff = PEND_W'(deleg_i & ~FIXED_M);

  generate
    if (HAS_BUSERR) begin : g_berr
      always_comb begin
        pending = low_pend;
        pending[BUSERR_CAUSE] = buserr_i;
      end
    end else begin : g_noberr
      logic unused_berr;
      assign unused_berr = buserr_i;
      assign pending = low_pend;
    end
  endgenerate

  assign mach_ok_o  = mach_allowed(priv_e'(priv_i), m_gie_i);
  assign sup_ok_o   = sup_allowed(priv_e'(priv_i), s_gie_i);
  assign mach_vec_o = mach_ok_o ? (pending & ~deleg_eff) : '0;
  assign sup_vec_o  = sup_ok_o  ? (pending & deleg_eff)  : '0;

endmodule

// File: rtl/irq_group_scan.sv
module irq_group_scan
  import irq_prio_pkg::*;
#(
  parameter int W       = 16,
  parameter int CAUSE_W = 8
) (
  input  logic [W-1:0]       vec_i,
  output logic               hit_o,
  output logic [CAUSE_W-1:0] cause_o
);

  always_comb begin
    hit_o   = 1'b0;
    cause_o = '0;
    for (int i = W - 1; i >= NONSTD_BASE; i--) begin
      if (!hit_o && vec_i[i]) begin
        hit_o   = 1'b1;
        cause_o = CAUSE_W'(i);
      end
    end
    for (int k = 0; k < STD_CNT; k++) begin
      if (std_slot(k) < W) begin
        if (!hit_o && vec_i[std_slot(k)]) begin
          hit_o   = 1'b1;
          cause_o = CAUSE_W'(std_slot(k));
        end
      end
    end
  end

endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int LOW_W        = 16,
  parameter int XLEN         = 64,
  parameter bit HAS_BUSERR   = 1'b1,
  parameter int BUSERR_CAUSE = 128,
  parameter int DEBUG_CAUSE  = 14,
  localparam int CAUSE_W     = $clog2(BUSERR_CAUSE + 1),
  localparam int PEND_W      = HAS_BUSERR ? BUSERR_CAUSE + 1 : LOW_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LOW_W-1:0]   pend_i,
  input  logic [LOW_W-1:0]   en_i,
  input  logic [LOW_W-1:0]   deleg_i,
  input  logic [1:0]         priv_i,
  input  logic               m_gie_i,
  input  logic               s_gie_i,
  input  logic               dbg_req_i,
  input  logic               buserr_i,
  input  logic [XLEN-1:0]    cause_wdata_i,
  output logic               irq_take_o,
  output logic [CAUSE_W-1:0] irq_cause_o,
  output logic [XLEN-1:0]    cause_wr_o
);

  localparam logic [XLEN-1:0] CAUSE_KEEP =
    {1'b1, {(XLEN-1-CAUSE_W){1'b0}}, {CAUSE_W{1'b1}}};

  // Named internal events, visible to the bound checker.
  logic [PEND_W-1:0]  mach_vec, sup_vec;
  logic               mach_ok, sup_ok;
  logic [PEND_W-1:0]  grp_vec   [NGRP];
  logic [NGRP-1:0]    grp_hit;
  logic [CAUSE_W-1:0] grp_cause [NGRP];
  logic               win_hit;
  logic [CAUSE_W-1:0] win_cause;

  irq_gate #(
    .LOW_W(LOW_W), .HAS_BUSERR(HAS_BUSERR), .BUSERR_CAUSE(BUSERR_CAUSE)
  ) gate_i (
    .pend_i(pend_i), .en_i(en_i), .deleg_i(deleg_i), .priv_i(priv_i),
    .m_gie_i(m_gie_i), .s_gie_i(s_gie_i), .buserr_i(buserr_i),
    .mach_vec_o(mach_vec), .sup_vec_o(sup_vec),
    .mach_ok_o(mach_ok), .sup_ok_o(sup_ok)
  );

  // Group 0 = debug, 1 = machine, 2 = supervisor (scan order).
  assign grp_vec[0] = PEND_W'(dbg_req_i) << DEBUG_CAUSE;
  assign grp_vec[1] = mach_vec;
  assign grp_vec[2] = sup_vec;

  generate
    for (genvar g = 0; g < NGRP; g++) begin : g_scan
      irq_group_scan #(.W(PEND_W), .CAUSE_W(CAUSE_W)) scan_i (
        .vec_i(grp_vec[g]), .hit_o(grp_hit[g]), .cause_o(grp_cause[g])
      );
    end
  endgenerate

  always_comb begin
    win_hit   = 1'b0;
    win_cause = '0;
    for (int g = 0; g < NGRP; g++) begin
      if (!win_hit && grp_hit[g]) begin
        win_hit   = 1'b1;
        win_cause = grp_cause[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_take_o  <= 1'b0;
      irq_cause_o <= '0;
    end else begin
      irq_take_o  <= win_hit;
      irq_cause_o <= win_cause;
    end
  end

  assign cause_wr_o = cause_wdata_i & CAUSE_KEEP;

endmodule

// File: rtl/irq_prio_sel_chk.sv
module irq_prio_sel_chk #(
  parameter int LOW_W        = 16,
  parameter int XLEN         = 64,
  parameter bit HAS_BUSERR   = 1'b1,
  parameter int BUSERR_CAUSE = 128,
  parameter int DEBUG_CAUSE  = 14,
  parameter int CAUSE_W      = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [1:0]         priv_i,
  input logic               m_gie_i,
  input logic               dbg_req_i,
  input logic               buserr_i,
  input logic [XLEN-1:0]    cause_wdata_i,
  input logic               irq_take_o,
  input logic [CAUSE_W-1:0] irq_cause_o,
  input logic [XLEN-1:0]    cause_wr_o,
  input logic               mach_ok,
  input logic [2:0]         grp_hit
);

  AST_DEBUG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_req_i |=> (irq_take_o && irq_cause_o == CAUSE_W'(DEBUG_CAUSE))); // R2

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_take_o |-> (irq_cause_o == '0)); // R8

  AST_M_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_i == 2'd3 && !m_gie_i && !dbg_req_i) |=> !irq_take_o); // R3

  AST_TAKE_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|grp_hit) |=> irq_take_o); // R1

  AST_QUIET_FOLLOWS_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|grp_hit) |=> !irq_take_o); // R1

  generate
    if (HAS_BUSERR) begin : g_berr_chk
      AST_BUSERR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (buserr_i && mach_ok && !dbg_req_i)
          |=> (irq_cause_o == CAUSE_W'(BUSERR_CAUSE))); // R5
    end
  endgenerate

  always_comb begin
    if (rst_n) begin
      AST_WMASK_KEEP: assert ((cause_wr_o[XLEN-2:CAUSE_W] == '0)
        && (cause_wr_o[XLEN-1] == cause_wdata_i[XLEN-1])
        && (cause_wr_o[CAUSE_W-1:0] == cause_wdata_i[CAUSE_W-1:0])); // R9
    end
  end

endmodule

bind irq_prio_sel irq_prio_sel_chk #(
  .LOW_W(LOW_W), .XLEN(XLEN), .HAS_BUSERR(HAS_BUSERR),
  .BUSERR_CAUSE(BUSERR_CAUSE), .DEBUG_CAUSE(DEBUG_CAUSE), .CAUSE_W(CAUSE_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .priv_i(priv_i), .m_gie_i(m_gie_i),
  .dbg_req_i(dbg_req_i), .buserr_i(buserr_i), .cause_wdata_i(cause_wdata_i),
  .irq_take_o(irq_take_o), .irq_cause_o(irq_cause_o), .cause_wr_o(cause_wr_o),
  .mach_ok(mach_ok), .grp_hit(grp_hit)
);

// File: tb/irq_prio_sel_tb.sv
`timescale 1ns/1ps
module irq_prio_sel_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] pend, en, deleg;
  logic [1:0]  priv;
  logic        mgie, sgie, dbg, berr;
  logic [63:0] wdata;
  logic        take;
  logic [7:0]  cause;
  logic [63:0] wr;

  int n_cmp = 0;
  int n_bad = 0;
  bit exp_take;
  int exp_cause;

  always #10 clk = ~clk;

  irq_prio_sel dut_i (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .m_gie_i(mgie), .s_gie_i(sgie), .dbg_req_i(dbg),
    .buserr_i(berr), .cause_wdata_i(wdata), .irq_take_o(take),
    .irq_cause_o(cause), .cause_wr_o(wr)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Behavioural model: walk a queue of causes in priority order.
  task automatic model(output bit t, output int c);
    int ord[$];
    int stdq[$] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
    bit [128:0] p, dl, grp[3];
    bit mon, son;
    p = '0; dl = '0;
    for (int i = 0; i < 16; i++) begin
      p[i]  = pend[i] & en[i];
      dl[i] = deleg[i] && (i != 3) && (i != 7) && (i != 11);
    end
    p[128] = berr;
    mon = (priv != 2'd3) || mgie;
    son = (priv == 2'd0) || (priv == 2'd1 && sgie);
    grp[0] = '0; grp[0][14] = dbg;
    grp[1] = mon ? (p & ~dl) : '0;
    grp[2] = son ? (p & dl) : '0;
    for (int i = 128; i >= 12; i--) ord.push_back(i);
    foreach (stdq[k]) ord.push_back(stdq[k]);
    t = 0; c = 0;
    for (int g = 0; g < 3; g++)
      foreach (ord[k])
        if (!t && grp[g][ord[k]]) begin t = 1; c = ord[k]; end
  endtask

  // Caller sets inputs just after a falling edge.
  task automatic step(string tag);
    model(exp_take, exp_cause);
    #1;
    chk({tag, " wmask R9"}, wr, wdata & 64'h8000_0000_0000_00FF);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " take"}, take, exp_take);
    chk({tag, " cause"}, cause, exp_cause);
  endtask

  task automatic clear();
    pend = '0; en = '0; deleg = '0; priv = 2'd3;
    mgie = 1'b0; sgie = 1'b0; dbg = 1'b0; berr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int std_ord[9] = '{11, 3, 7, 9, 1, 5, 8, 0, 4};
    clear(); wdata = '0; rst_n = 1'b0;
    pend = 16'hFFFF; en = 16'hFFFF; mgie = 1'b1; dbg = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset take", take, 0);
    chk("R1 reset cause", cause, 0);
    rst_n = 1'b1; clear();
    step("R8 idle");

    // R1: result appears only after the edge
    pend = 16'h0080; en = 16'h0080; mgie = 1'b1;
    #1 chk("R1 before edge", take, 0);
    @(negedge clk);
    step("R1 after edge");

    // R3 machine gating
    clear(); pend = 16'h0080; en = 16'h0080; mgie = 1'b1; step("R3 M gie on");
    mgie = 1'b0; step("R3 M gie off");
    priv = 2'd1; step("R3 S lower priv");
    priv = 2'd0; step("R3 U lower priv");

    // R7 standard order, strip winners one by one
    clear(); priv = 2'd0; pend = 16'h0FFF; en = 16'h0FFF;
    for (int k = 0; k < 9; k++) begin
      wdata = {$urandom, $urandom};
      step("R7 std order");
      pend[std_ord[k]] = 1'b0;
    end
    wdata = 64'hFFFF_FFFF_FFFF_FFFF; step("R9 all ones");
    pend = 16'h8800; en = 16'hFFFF; step("R7 nonstd 15 over 11");
    pend = 16'h3000; step("R7 nonstd 13 over 12");

    // R5 enable and bus error
    clear(); pend = 16'h0800; en = 16'h0000; mgie = 1'b1; step("R5 not enabled");
    berr = 1'b1; step("R5 buserr ignores enable");
    pend = 16'h8800; en = 16'hFFFF; step("R5 buserr over nonstd");

    // R6 non-delegable
    clear(); berr = 1'b1; deleg = 16'hFFFF; mgie = 1'b1; step("R6 buserr not delegated");
    priv = 2'd1; mgie = 1'b0; sgie = 1'b0; step("R6 buserr in S");
    clear(); deleg = 16'hFFFF; pend = 16'h0A00; en = 16'h0A00; mgie = 1'b1;
    step("R6 bit11 stays machine");
    pend = 16'h0088; en = 16'h0088; step("R6 bits 3 7 stay machine");

    // R2 debug and group order
    clear(); dbg = 1'b1; berr = 1'b1; mgie = 1'b1; step("R2 debug over buserr");
    mgie = 1'b0; step("R2 debug ignores gating");
    clear(); priv = 2'd0; deleg = 16'h0200; pend = 16'h0210; en = 16'h0210;
    step("R2 machine over supervisor");

    // R4 supervisor gating
    clear(); deleg = 16'h0002; pend = 16'h0002; en = 16'h0002;
    priv = 2'd1; sgie = 1'b1; step("R4 S sie on");
    sgie = 1'b0; step("R4 S sie off");
    priv = 2'd0; step("R4 U always");
    priv = 2'd3; sgie = 1'b1; mgie = 1'b1; step("R4 M blocks supervisor");

    // Mixed patterns
    for (int n = 0; n < 1500; n++) begin
      pend = 16'($urandom); en = 16'($urandom); deleg = 16'($urandom);
      priv = 2'($urandom); mgie = 1'($urandom); sgie = 1'($urandom);
      dbg = ($urandom % 8) == 0; berr = ($urandom % 4) == 0;
      wdata = {$urandom, $urandom};
      step("R7 R3 R4 mixed");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule